// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer with Static Fallback

This block predicts the outcome of branches on the fetch side. It keeps recently resolved branches in a table of four-way sets. Each entry carries an address tag, the target the branch jumped to the last time it was taken, and a four-bit record of its latest outcomes. On a lookup that hits, the history of the matching entry selects a two-bit counter in a small shared pattern table, and that counter gives the direction. A taken prediction returns the stored target as the next fetch address. On a lookup that misses, a fixed rule decides the direction. The rule uses the branch kind supplied by predecode and, for PC-relative conditional branches, the sign of the offset.

The fetch unit presents a PC with its predecode hints on the lookup port and receives the prediction one cycle later. The execute side reports each resolved branch on the update port. A resolved branch that is already in the table has its history shifted and its pattern counter trained. A resolved branch that is not in the table is written into its set. The fill takes the lowest free way, or the way chosen by a tree pseudo-LRU when the set is full.

Top module: `btb_predictor`

## Requirements
- R1: A lookup presented with `lk_valid` high in one cycle produces its result on the outputs in the next cycle with `pred_valid` high. In any cycle that follows a cycle without a lookup, and after reset, `pred_valid`, `pred_hit`, `pred_taken` and `pred_target` are all zero.
- R2: The default table has 128 sets of 4 ways. The set index is `pc[8:2]` and the tag is `pc[31:9]`. Four branches that share a set are all kept. A PC with the same index but a different tag misses.
- R3: On a hit, the direction comes from the pattern table entry selected by the entry's history, and the predecode hints are ignored. `pred_target` carries the stored target when the prediction is taken and is zero in every other case.
- R4: A resolved branch that hits shifts its history left and inserts the new outcome in bit 0 (taken = 1). A fill sets all four history bits to the outcome.
- R5: The pattern table holds 16 shared entries, one for each history value. Each entry has a trained flag and a 2-bit counter, and the direction is the counter MSB. An untrained entry predicts taken. The first training of an entry sets its counter to 2'b10 for taken or 2'b01 for not taken. Later trainings count up on taken and down on not taken, and the count saturates at 2'b11 and 2'b00. Only updates that hit train the table, and they train the entry selected by the history held before the shift.
- R6: An update that hits rewrites the stored target only when the outcome is taken. A fill always stores `up_target`.
- R7: A fill uses the lowest-numbered invalid way of its set. If the set is full, the fill uses the tree pseudo-LRU victim. The tree is touched by every fill, every update hit and every lookup hit. The fill order of branches into an empty set is therefore way 0, 1, 2, 3.
- R8: On a miss, the `lk_kind` code decides the direction. Code 2'b00 (PC-relative conditional) predicts taken exactly when `lk_backward` is 1. Code 2'b01 (return) predicts taken. Codes 2'b10 (indirect) and 2'b11 (other) predict not taken. `lk_backward` has no effect outside code 2'b00.
- R9: When a lookup and an update address the same set in one cycle, the update's replacement touch is applied and the lookup's touch is dropped. The lookup sees the table contents from before the update.
- R10: Reset invalidates every entry and leaves every pattern entry untrained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_kind | input | 2 | Predecode branch kind code |
| lk_backward | input | 1 | PC-relative offset is negative |
| up_valid | input | 1 | Resolved branch report this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_target | input | 32 | Resolved branch destination |
| pred_valid | output | 1 | Prediction result is present |
| pred_hit | output | 1 | Lookup matched a table entry |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted next fetch address, zero unless hit and taken |

## Verification
The assertions assume that `lk_kind` and `lk_backward` are known whenever `lk_valid` is high, and that the control inputs hold defined values from the first clock after reset. They also assume that updates only come from branches that really resolved, so no PC ever sits in two ways of a set. The stimulus drives every input at the falling edge and returns the strobes to zero between operations. It reports each branch once as a miss before reporting it as a hit. The collision case is exercised by one cycle that carries both strobes on the same set.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        KIND_REL_COND = 2'b00,
        KIND_RETURN   = 2'b01,
        KIND_INDIRECT = 2'b10,
        KIND_OTHER    = 2'b11
    } br_kind_e;

    // Direction used when the lookup misses the table
    function automatic logic static_dir(input br_kind_e kind, input logic backward);
        logic dir;
        case (kind)
            KIND_REL_COND: dir = backward;
            KIND_RETURN:   dir = 1'b1;
            default:       dir = 1'b0;
        endcase
        return dir;
    endfunction

endpackage

// File: rtl/btb_way.sv
module btb_way #(
    parameter int SETS   = 128,
    parameter int TAG_W  = 23,
    parameter int PC_W   = 32,
    parameter int HIST_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  lk_idx,
    output logic                     lk_valid_o,
    output logic [TAG_W-1:0]         lk_tag_o,
    output logic [PC_W-1:0]          lk_target_o,
    output logic [HIST_W-1:0]        lk_hist_o,
    input  logic [$clog2(SETS)-1:0]  up_idx,
    output logic                     up_valid_o,
    output logic [TAG_W-1:0]         up_tag_o,
    output logic [HIST_W-1:0]        up_hist_o,
    input  logic                     wr_en,
    input  logic                     wr_fill,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic                     wr_tgt_en,
    input  logic [PC_W-1:0]          wr_target,
    input  logic [HIST_W-1:0]        wr_hist
);

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [PC_W-1:0]   target;
        logic [HIST_W-1:0] hist;
    } entry_t;

    entry_t mem_q [SETS];
    entry_t mem_d [SETS];

    assign lk_valid_o  = mem_q[lk_idx].valid;
    assign lk_tag_o    = mem_q[lk_idx].tag;
    assign lk_target_o = mem_q[lk_idx].target;
    assign lk_hist_o   = mem_q[lk_idx].hist;
    assign up_valid_o  = mem_q[up_idx].valid;
    assign up_tag_o    = mem_q[up_idx].tag;
    assign up_hist_o   = mem_q[up_idx].hist;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[up_idx].valid = 1'b1;
            mem_d[up_idx].hist  = wr_hist;
            if (wr_fill)   mem_d[up_idx].tag    = wr_tag;
            if (wr_tgt_en) mem_d[up_idx].target = wr_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/btb_plru.sv
module btb_plru #(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_touch,
    input  logic [$clog2(SETS)-1:0]  lk_idx,
    input  logic [$clog2(WAYS)-1:0]  lk_way,
    input  logic                     up_touch,
    input  logic [$clog2(SETS)-1:0]  up_idx,
    input  logic [$clog2(WAYS)-1:0]  up_way,
    output logic [$clog2(WAYS)-1:0]  vic_way
);

    localparam int WAY_W = $clog2(WAYS);
    localparam int NODES = WAYS - 1;

    logic [NODES-1:0] tree_q [SETS];
    logic [NODES-1:0] tree_d [SETS];

    // Point every node on the path of way w away from it
    function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                              input logic [WAY_W-1:0] w);
        logic [NODES-1:0] r;
        int node;
        r    = t;
        node = 1;
        for (int l = 0; l < WAY_W; l++) begin
            r[node-1] = ~w[WAY_W-1-l];
            node      = 2 * node + int'(w[WAY_W-1-l]);
        end
        return r;
    endfunction

    // Follow the node bits down to a leaf
    function automatic logic [WAY_W-1:0] victim(input logic [NODES-1:0] t);
        int node;
        node = 1;
        for (int l = 0; l < WAY_W; l++) begin
            node = 2 * node + int'(t[node-1]);
        end
        return WAY_W'(node - WAYS);
    endfunction

    assign vic_way = victim(tree_q[up_idx]);

    always_comb begin
        tree_d = tree_q;
        if (up_touch)
            tree_d[up_idx] = touch(tree_q[up_idx], up_way);
        if (lk_touch && !(up_touch && (lk_idx == up_idx)))
            tree_d[lk_idx] = touch(tree_q[lk_idx], lk_way);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) tree_q[i] <= '0;
        end else begin
            tree_q <= tree_d;
        end
    end

endmodule

// File: rtl/btb_pattern.sv
module btb_pattern #(
    parameter int HIST_W        = 4,
    parameter bit DEFAULT_TAKEN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_hist,
    output logic              rd_taken,
    input  logic              train_en,
    input  logic [HIST_W-1:0] train_hist,
    input  logic              train_taken
);

    localparam int ENTRIES = 1 << HIST_W;

    typedef struct packed {
        logic       trained;
        logic [1:0] ctr;
    } pat_t;

    pat_t pat_q [ENTRIES];
    pat_t pat_d [ENTRIES];

    assign rd_taken = pat_q[rd_hist].trained ? pat_q[rd_hist].ctr[1] : DEFAULT_TAKEN;

    always_comb begin
        pat_d = pat_q;
        if (train_en) begin
            if (!pat_q[train_hist].trained) begin
                pat_d[train_hist].trained = 1'b1;
                pat_d[train_hist].ctr     = train_taken ? 2'b10 : 2'b01;
            end else if (train_taken && pat_q[train_hist].ctr != 2'b11) begin
                pat_d[train_hist].ctr = pat_q[train_hist].ctr + 2'd1;
            end else if (!train_taken && pat_q[train_hist].ctr != 2'b00) begin
                pat_d[train_hist].ctr = pat_q[train_hist].ctr - 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) pat_q[i] <= '0;
        end else begin
            pat_q <= pat_d;
        end
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
    parameter int PC_W          = 32,
    parameter int SETS          = 128,
    parameter int WAYS          = 4,
    parameter int HIST_W        = 4,
    parameter int INSN_SHIFT    = 2,
    parameter bit DEFAULT_TAKEN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic [1:0]      lk_kind,
    input  logic            lk_backward,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_target,
    output logic            pred_valid,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target
);

    import btb_pkg::*;

    localparam int SET_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int TAG_LSB = INSN_SHIFT + SET_W;
    localparam int TAG_W   = PC_W - TAG_LSB;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            taken;
        logic [PC_W-1:0] target;
    } pred_t;

    pred_t state_q, state_d;

    logic [SET_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic unused_low_bits;

    assign lk_idx = lk_pc[INSN_SHIFT +: SET_W];
    assign up_idx = up_pc[INSN_SHIFT +: SET_W];
    assign lk_tag = lk_pc[PC_W-1:TAG_LSB];
    assign up_tag = up_pc[PC_W-1:TAG_LSB];
    assign unused_low_bits = ^{lk_pc[INSN_SHIFT-1:0], up_pc[INSN_SHIFT-1:0]};

    // Per-way read data
    logic [WAYS-1:0]   lk_v, up_v, wr_en;
    logic [TAG_W-1:0]  lk_tag_arr [WAYS];
    logic [TAG_W-1:0]  up_tag_arr [WAYS];
    logic [PC_W-1:0]   lk_tgt_arr [WAYS];
    logic [HIST_W-1:0] lk_hist_arr [WAYS];
    logic [HIST_W-1:0] up_hist_arr [WAYS];

    // Shared write data
    logic              wr_fill, wr_tgt_en;
    logic [HIST_W-1:0] wr_hist;

    // Hit and way selection
    logic              lk_hit, up_hit, has_free;
    logic [WAY_W-1:0]  lk_way, up_hit_way, free_way, vic_way, up_way;
    logic [HIST_W-1:0] lk_hist_sel, up_hist_sel;
    logic              pat_taken;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            btb_way #(
                .SETS(SETS), .TAG_W(TAG_W), .PC_W(PC_W), .HIST_W(HIST_W)
            ) u_way (
                .clk(clk),
                .rst_n(rst_n),
                .lk_idx(lk_idx),
                .lk_valid_o(lk_v[w]),
                .lk_tag_o(lk_tag_arr[w]),
                .lk_target_o(lk_tgt_arr[w]),
                .lk_hist_o(lk_hist_arr[w]),
                .up_idx(up_idx),
                .up_valid_o(up_v[w]),
                .up_tag_o(up_tag_arr[w]),
                .up_hist_o(up_hist_arr[w]),
                .wr_en(wr_en[w]),
                .wr_fill(wr_fill),
                .wr_tag(up_tag),
                .wr_tgt_en(wr_tgt_en),
                .wr_target(up_target),
                .wr_hist(wr_hist)
            );
            assign wr_en[w] = up_valid && (up_way == WAY_W'(w));
        end
    endgenerate

    btb_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk(clk),
        .rst_n(rst_n),
        .lk_touch(lk_valid && lk_hit),
        .lk_idx(lk_idx),
        .lk_way(lk_way),
        .up_touch(up_valid),
        .up_idx(up_idx),
        .up_way(up_way),
        .vic_way(vic_way)
    );

    btb_pattern #(.HIST_W(HIST_W), .DEFAULT_TAKEN(DEFAULT_TAKEN)) u_pattern (
        .clk(clk),
        .rst_n(rst_n),
        .rd_hist(lk_hist_sel),
        .rd_taken(pat_taken),
        .train_en(up_valid && up_hit),
        .train_hist(up_hist_sel),
        .train_taken(up_taken)
    );

    // Tag match on both ports, lowest free way for fills
    always_comb begin
        lk_hit     = 1'b0;
        lk_way     = '0;
        up_hit     = 1'b0;
        up_hit_way = '0;
        has_free   = 1'b0;
        free_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!lk_hit && lk_v[w] && (lk_tag_arr[w] == lk_tag)) begin
                lk_hit = 1'b1;
                lk_way = WAY_W'(w);
            end
            if (!up_hit && up_v[w] && (up_tag_arr[w] == up_tag)) begin
                up_hit     = 1'b1;
                up_hit_way = WAY_W'(w);
            end
            if (!has_free && !up_v[w]) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        lk_hist_sel = lk_hist_arr[lk_way];
        up_hist_sel = up_hist_arr[up_hit_way];
    end

    // Update-side write decisions
    always_comb begin
        if (up_hit)        up_way = up_hit_way;
        else if (has_free) up_way = free_way;
        else               up_way = vic_way;
        wr_fill   = !up_hit;
        wr_tgt_en = !up_hit || up_taken;
        wr_hist   = up_hit ? {up_hist_sel[HIST_W-2:0], up_taken} : {HIST_W{up_taken}};
    end

    // Lookup result, registered for the next cycle
    always_comb begin
        state_d.valid  = lk_valid;
        state_d.hit    = lk_valid && lk_hit;
        state_d.taken  = lk_valid && (lk_hit ? pat_taken
                                             : static_dir(br_kind_e'(lk_kind), lk_backward));
        state_d.target = (lk_valid && lk_hit && pat_taken) ? lk_tgt_arr[lk_way] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pred_valid  = state_q.valid;
    assign pred_hit    = state_q.hit;
    assign pred_taken  = state_q.taken;
    assign pred_target = state_q.target;

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [1:0]      lk_kind,
    input logic            lk_backward,
    input logic            pred_valid,
    input logic            pred_hit,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_target
);

    // R1
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pred_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!pred_valid && !pred_hit && !pred_taken && pred_target == '0));

    // R3
    tgt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !(pred_hit && pred_taken)) |-> (pred_target == '0));

    // R8
    rel_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind == 2'b00) |=> (pred_hit || (pred_taken == $past(lk_backward))));

    // R8
    ret_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind == 2'b01) |=> (pred_hit || pred_taken));

    // R8
    other_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind[1]) |=> (pred_hit || !pred_taken));

endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_backward = 1'b0;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [31:0] up_target = '0;
    logic        pred_valid, pred_hit, pred_taken;
    logic [31:0] pred_target;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    btb_predictor u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind), .lk_backward(lk_backward),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target),
        .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken),
        .pred_target(pred_target)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic expect_pred(input string req, input logic hit,
                               input logic taken, input logic [31:0] tgt);
        chk(req, "pred_valid", {31'd0, pred_valid}, 32'd1);
        chk(req, "pred_hit", {31'd0, pred_hit}, {31'd0, hit});
        chk(req, "pred_taken", {31'd0, pred_taken}, {31'd0, taken});
        chk(req, "pred_target", pred_target, tgt);
    endtask

    // Result is registered at the edge between the two falling edges
    task automatic lookup(input logic [31:0] pc, input logic [1:0] kind, input logic back);
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc; lk_kind = kind; lk_backward = back;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic update(input logic [31:0] pc, input logic taken, input logic [31:0] tgt);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_taken = taken; up_target = tgt;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10", "pred_valid", {31'd0, pred_valid}, 32'd0);
        chk("R1", "pred_hit", {31'd0, pred_hit}, 32'd0);
        chk("R1", "pred_taken", {31'd0, pred_taken}, 32'd0);
        chk("R1", "pred_target", pred_target, 32'd0);
        lookup(32'h0000_2000, 2'b10, 1'b0);
        expect_pred("R10", 1'b0, 1'b0, 32'd0);
    endtask

    task automatic t_static();
        lookup(32'h0000_1000, 2'b00, 1'b1);
        expect_pred("R8", 1'b0, 1'b1, 32'd0);
        lookup(32'h0000_1000, 2'b00, 1'b0);
        expect_pred("R8", 1'b0, 1'b0, 32'd0);
        lookup(32'h0000_1000, 2'b01, 1'b0);
        expect_pred("R8", 1'b0, 1'b1, 32'd0);
        lookup(32'h0000_1000, 2'b10, 1'b1);
        expect_pred("R8", 1'b0, 1'b0, 32'd0);
        lookup(32'h0000_1000, 2'b11, 1'b1);
        expect_pred("R8", 1'b0, 1'b0, 32'd0);
        @(negedge clk);
        chk("R1", "pred_valid idle", {31'd0, pred_valid}, 32'd0);
        chk("R1", "pred_taken idle", {31'd0, pred_taken}, 32'd0);
    endtask

    task automatic t_history();
        update(32'h0000_2000, 1'b1, 32'h0000_3000);
        lookup(32'h0000_2000, 2'b10, 1'b0);
        expect_pred("R5", 1'b1, 1'b1, 32'h0000_3000);
        update(32'h0000_2000, 1'b1, 32'h0000_3000);
        update(32'h0000_2000, 1'b0, 32'h0000_5555);
        lookup(32'h0000_2000, 2'b10, 1'b0);
        expect_pred("R6", 1'b1, 1'b1, 32'h0000_3000);
        update(32'h0000_2000, 1'b0, 32'h0000_5555);
        update(32'h0000_2004, 1'b1, 32'h0000_4000);
        lookup(32'h0000_2004, 2'b01, 1'b0);
        expect_pred("R3", 1'b1, 1'b0, 32'd0);
        for (int k = 0; k < 3; k++) update(32'h0000_2004, 1'b1, 32'h0000_4000);
        update(32'h0000_2008, 1'b1, 32'h0000_6000);
        update(32'h0000_2008, 1'b0, 32'h0000_6000);
        lookup(32'h0000_2004, 2'b10, 1'b0);
        expect_pred("R5", 1'b1, 1'b1, 32'h0000_4000);
        lookup(32'h0000_2008, 2'b01, 1'b0);
        expect_pred("R4", 1'b1, 1'b0, 32'd0);
        lookup(32'h0000_2200, 2'b00, 1'b1);
        expect_pred("R2", 1'b0, 1'b1, 32'd0);
    endtask

    task automatic t_replace();
        for (int k = 0; k < 4; k++)
            update(32'h0000_4014 + 32'(k) * 32'h200, 1'b1, 32'h0000_7000 + 32'(k) * 32'h10);
        for (int k = 0; k < 4; k++) begin
            lookup(32'h0000_4014 + 32'(k) * 32'h200, 2'b10, 1'b0);
            expect_pred("R2", 1'b1, 1'b1, 32'h0000_7000 + 32'(k) * 32'h10);
        end
        // R9: same-set lookup and update in one cycle
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = 32'h0000_4014; lk_kind = 2'b10; lk_backward = 1'b0;
        up_valid = 1'b1; up_pc = 32'h0000_4614; up_taken = 1'b1; up_target = 32'h0000_7030;
        @(negedge clk);
        lk_valid = 1'b0; up_valid = 1'b0;
        expect_pred("R9", 1'b1, 1'b1, 32'h0000_7000);
        update(32'h0000_4814, 1'b1, 32'h0000_7800);
        lookup(32'h0000_4014, 2'b10, 1'b0);
        expect_pred("R9", 1'b0, 1'b0, 32'd0);
        lookup(32'h0000_4814, 2'b10, 1'b0);
        expect_pred("R7", 1'b1, 1'b1, 32'h0000_7800);
        lookup(32'h0000_4214, 2'b10, 1'b0);
        expect_pred("R7", 1'b1, 1'b1, 32'h0000_7010);
        update(32'h0000_4A14, 1'b1, 32'h0000_7A00);
        lookup(32'h0000_4414, 2'b10, 1'b0);
        expect_pred("R7", 1'b0, 1'b0, 32'd0);
        lookup(32'h0000_4614, 2'b10, 1'b0);
        expect_pred("R7", 1'b1, 1'b1, 32'h0000_7030);
        lookup(32'h0000_4214, 2'b10, 1'b0);
        expect_pred("R7", 1'b1, 1'b1, 32'h0000_7010);
        lookup(32'h0000_4A14, 2'b10, 1'b0);
        expect_pred("R7", 1'b1, 1'b1, 32'h0000_7A00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_static();
        t_history();
        t_replace();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule